// File: doc/BRIEF.md
# SDRAM Manual Command Issue Unit

This block is the firmware-driven command path of a DDR2 memory controller. Firmware runs the power-up initialization and the self-refresh entry and exit through it. A single write of a 3-bit command code makes the unit do one of three things:

- emit exactly one precharge-all strobe;
- emit exactly one auto-refresh strobe;
- raise the memory clock-enable pin, which then stays high.

Each issued command starts a programmable spacing interval. A precharge-all uses the precharge time. An auto-refresh uses the refresh-to-next-command time.

A command written while the previous interval is still running is held in a single pending slot. The unit reports busy while that slot is full, and issues the held command in the first cycle the interval allows. The command field always reads back as zero. Writes are ignored outright while the automatic refresh scheduler is enabled. Prohibited codes produce an error pulse. So do commands written before clock enable is raised, and commands written while the slot is already full.

A self-refresh request drops clock enable. A release raises it again without any write from firmware.

The control is a four-state machine:

| State | Meaning |
|---|---|
| `ST_POWERUP` | Clock enable not yet raised. |
| `ST_READY` | Clock enable high, no interval running. |
| `ST_GAP` | Spacing interval counting down. |
| `ST_SELFREF` | Clock enable low for self-refresh. |

Its transitions are:

| Transition | Condition |
|---|---|
| `POWERUP->READY` | Write of code 011. |
| `READY->GAP` | A command is issued. |
| `GAP->GAP` | A held or freshly written command is issued as the interval expires. |
| `GAP->READY` | The interval expires with nothing to issue. |
| `READY->SELFREF` | `sr_enter` pulse. |
| `SELFREF->READY` | `sr_exit` pulse. |

Top module: `sdram_cmd_issuer`

## Requirements
- R1: After reset `cke`, `cmd_valid`, `busy` and `err` are all 0.
- R2: With the unit idle and clock enable high, writing code 010 gives one `cmd_valid` strobe with `cmd_type`=01 (precharge-all) in the cycle after the write. Code 100 gives the same with `cmd_type`=10 (auto-refresh). Each write gives exactly one strobe. Code 000 gives no strobe and no error.
- R3: Codes 001, 101, 110 and 111 give no strobe and pulse `err` for one cycle, in the cycle after the write.
- R4: `rd_data` is 000 at all times, whatever was written.
- R5: Code 011 drives `cke` high from the cycle after the write. No code lowers it, and writing 011 again changes nothing and raises no error.
- R6: Count the cycle of a strobe as cycle c. The next strobe comes no earlier than cycle c+max(`t_prech`,1) after a precharge-all, and no earlier than c+max(`t_refr`,1) after an auto-refresh.
- R7: A command written while an interval is running is held. `busy` is 1 from the cycle after the write, and the held command strobes in the first cycle R6 allows. `busy` is 0 in that strobe cycle.
- R8: A command write (010 or 100) that arrives while a command is already held is dropped and pulses `err` in the next cycle.
- R9: While `auto_ref_en` is 1, every write, including a prohibited code, is ignored: no strobe, no `err`, no change of `cke`.
- R10: Codes 010 and 100 written before `cke` has been raised are dropped and pulse `err` in the next cycle.
- R11: A pulse on `sr_enter` while `cke` is high, no interval is running and nothing is held drives `cke` low from the next cycle. Commands written during self-refresh are held (`busy`=1) and not issued. `sr_enter` in any other situation is ignored.
- R12: A pulse on `sr_exit` during self-refresh drives `cke` high in the next cycle. A held command strobes in the cycle after that.
- R13: `cmd_valid` is never 1 while `cke` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the command field |
| wr_data | input | 3 | Command code written |
| rd_data | output | 3 | Read value of the command field (always 000) |
| auto_ref_en | input | 1 | Automatic refresh scheduler enabled; locks the field |
| t_prech | input | TW | Spacing after precharge-all, in cycles |
| t_refr | input | TW | Spacing after auto-refresh, in cycles |
| sr_enter | input | 1 | Self-refresh entry request pulse |
| sr_exit | input | 1 | Self-refresh release pulse |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_type | output | 2 | 01 precharge-all, 10 auto-refresh |
| cke | output | 1 | Memory clock enable |
| busy | output | 1 | A command is held waiting |
| err | output | 1 | One-cycle error pulse |

## Verification
The bench builds the unit with a 4-bit timer width and spacing values of 3 and 5 cycles. With these values a second write lands inside a running interval, and a third lands in the very cycle the interval expires, within a handful of cycles. A run with the precharge time set to 0 reaches the clamp to one cycle, so back-to-back strobes on consecutive cycles are exercised. Self-refresh is entered with a command held across it. This makes the release-then-issue ordering observable at the ports.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [1:0] {
        ST_POWERUP,
        ST_READY,
        ST_GAP,
        ST_SELFREF
    } sdc_state_e;

    typedef enum logic [1:0] {
        CT_NONE = 2'b00,
        CT_PRE  = 2'b01,
        CT_REF  = 2'b10
    } sdc_ctype_e;

    localparam logic [2:0] CODE_NOP = 3'b000;
    localparam logic [2:0] CODE_PRE = 3'b010;
    localparam logic [2:0] CODE_CKE = 3'b011;
    localparam logic [2:0] CODE_REF = 3'b100;

endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
    import sdc_pkg::*;
(
    input  logic       wr_en,
    input  logic [2:0] wr_code,
    input  logic       locked,
    output logic       cmd_req,
    output sdc_ctype_e cmd_typ,
    output logic       cke_req,
    output logic       bad_code
);
    always_comb begin
        cmd_req  = 1'b0;
        cmd_typ  = CT_NONE;
        cke_req  = 1'b0;
        bad_code = 1'b0;
        if (wr_en && !locked) begin
            unique case (wr_code)
                CODE_NOP: ;
                CODE_PRE: begin
                    cmd_req = 1'b1;
                    cmd_typ = CT_PRE;
                end
                CODE_REF: begin
                    cmd_req = 1'b1;
                    cmd_typ = CT_REF;
                end
                CODE_CKE: cke_req = 1'b1;
                default:  bad_code = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/sdc_gap_timer.sv
module sdc_gap_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expiring
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? ONE : load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expiring = (cnt_q <= ONE);
endmodule

// File: rtl/sdc_pend_slot.sv
module sdc_pend_slot
    import sdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set,
    input  sdc_ctype_e set_typ,
    input  logic       clr,
    output logic       valid,
    output sdc_ctype_e typ
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            typ   <= CT_NONE;
        end else if (set) begin
            valid <= 1'b1;
            typ   <= set_typ;
        end else if (clr) begin
            valid <= 1'b0;
            typ   <= CT_NONE;
        end
    end
endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
    import sdc_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_data,
    output logic [2:0]    rd_data,
    input  logic          auto_ref_en,
    input  logic [TW-1:0] t_prech,
    input  logic [TW-1:0] t_refr,
    input  logic          sr_enter,
    input  logic          sr_exit,
    output logic          cmd_valid,
    output logic [1:0]    cmd_type,
    output logic          cke,
    output logic          busy,
    output logic          err
);
    sdc_state_e state_q, state_d;

    logic       cmd_req, cke_req, bad_code;
    sdc_ctype_e cmd_typ;
    logic       tmr_expiring;
    logic       pend_valid;
    sdc_ctype_e pend_typ;

    logic       issue;
    sdc_ctype_e issue_typ;
    logic       pend_set, pend_clr;
    logic       err_d;
    logic [TW-1:0] gap_val;

    sdc_cmd_decode u_dec (
        .wr_en    (wr_en),
        .wr_code  (wr_data),
        .locked   (auto_ref_en),
        .cmd_req  (cmd_req),
        .cmd_typ  (cmd_typ),
        .cke_req  (cke_req),
        .bad_code (bad_code)
    );

    assign gap_val = (issue_typ == CT_PRE) ? t_prech : t_refr;

    sdc_gap_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (issue),
        .load_val (gap_val),
        .expiring (tmr_expiring)
    );

    sdc_pend_slot u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (pend_set),
        .set_typ (cmd_typ),
        .clr     (pend_clr),
        .valid   (pend_valid),
        .typ     (pend_typ)
    );

    // next-state and command selection
    always_comb begin
        state_d   = state_q;
        issue     = 1'b0;
        issue_typ = CT_NONE;
        pend_set  = 1'b0;
        pend_clr  = 1'b0;
        err_d     = bad_code;
        unique case (state_q)
            ST_POWERUP: begin
                if (cke_req) begin
                    state_d = ST_READY;
                end else if (cmd_req) begin
                    err_d = 1'b1;
                end
            end
            ST_READY: begin
                if (pend_valid) begin
                    issue     = 1'b1;
                    issue_typ = pend_typ;
                    pend_clr  = 1'b1;
                    if (cmd_req) err_d = 1'b1;
                end else if (cmd_req) begin
                    issue     = 1'b1;
                    issue_typ = cmd_typ;
                end else if (sr_enter) begin
                    state_d = ST_SELFREF;
                end
                if (issue) state_d = ST_GAP;
            end
            ST_GAP: begin
                if (tmr_expiring) begin
                    if (pend_valid) begin
                        issue     = 1'b1;
                        issue_typ = pend_typ;
                        pend_clr  = 1'b1;
                        if (cmd_req) err_d = 1'b1;
                    end else if (cmd_req) begin
                        issue     = 1'b1;
                        issue_typ = cmd_typ;
                    end else begin
                        state_d = ST_READY;
                    end
                end else if (cmd_req) begin
                    if (pend_valid) err_d = 1'b1;
                    else            pend_set = 1'b1;
                end
            end
            ST_SELFREF: begin
                if (cmd_req) begin
                    if (pend_valid) err_d = 1'b1;
                    else            pend_set = 1'b1;
                end
                if (sr_exit) state_d = ST_READY;
            end
            default: state_d = ST_POWERUP;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_POWERUP;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_type  <= CT_NONE;
            err       <= 1'b0;
        end else begin
            cmd_valid <= issue;
            cmd_type  <= issue ? issue_typ : CT_NONE;
            err       <= err_d;
        end
    end

    assign cke     = (state_q == ST_READY) || (state_q == ST_GAP);
    assign busy    = pend_valid;
    assign rd_data = 3'b000;
endmodule

// File: rtl/sdc_issue_chk.sv
module sdc_issue_chk #(
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    wr_data,
    input logic          auto_ref_en,
    input logic [TW-1:0] t_prech,
    input logic [TW-1:0] t_refr,
    input logic          sr_enter,
    input logic          cmd_valid,
    input logic [1:0]    cmd_type,
    input logic          cke,
    input logic          err
);
    logic [TW-1:0] tp_prev, tr_prev, need_q;
    logic [TW:0]   since_q;
    logic          seen_q;
    logic          bad_wr;

    assign bad_wr = wr_en && !auto_ref_en &&
                    (wr_data == 3'b001 || wr_data[2:0] >= 3'b101);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tp_prev <= '0;
            tr_prev <= '0;
            need_q  <= '0;
            since_q <= '0;
            seen_q  <= 1'b0;
        end else begin
            tp_prev <= t_prech;
            tr_prev <= t_refr;
            if (cmd_valid) begin
                seen_q  <= 1'b1;
                since_q <= (TW+1)'(1);
                if (cmd_type == 2'b01)
                    need_q <= (tp_prev == '0) ? TW'(1) : tp_prev;
                else
                    need_q <= (tr_prev == '0) ? TW'(1) : tr_prev;
            end else if (since_q != '1) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    assert_strobe_cke_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cke);

    assert_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && seen_q) |-> (since_q >= {1'b0, need_q}));

    assert_locked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && auto_ref_en) |=> !err);

    assert_bad_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> err);

    assert_cke_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> $past(sr_enter));

    assert_type_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($countones(cmd_type) == 1));
endmodule

bind sdram_cmd_issuer sdc_issue_chk #(.TW(TW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .auto_ref_en (auto_ref_en),
    .t_prech     (t_prech),
    .t_refr      (t_refr),
    .sr_enter    (sr_enter),
    .cmd_valid   (cmd_valid),
    .cmd_type    (cmd_type),
    .cke         (cke),
    .err         (err)
);

// File: tb/sdram_cmd_issuer_tb_top.sv
module sdram_cmd_issuer_tb_top;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_data = 3'b000;
    logic [2:0]    rd_data;
    logic          auto_ref_en = 1'b0;
    logic [TW-1:0] t_prech = TW'(3);
    logic [TW-1:0] t_refr = TW'(5);
    logic          sr_enter = 1'b0;
    logic          sr_exit = 1'b0;
    logic          cmd_valid;
    logic [1:0]    cmd_type;
    logic          cke;
    logic          busy;
    logic          err;

    sdram_cmd_issuer #(.TW(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .auto_ref_en(auto_ref_en), .t_prech(t_prech),
        .t_refr(t_refr), .sr_enter(sr_enter), .sr_exit(sr_exit),
        .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cke(cke),
        .busy(busy), .err(err)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         at;
        logic [1:0] typ;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    int   last_c = -1000;
    int   last_gap = 1;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // expected strobe cycle for a command written in cycle w
    function automatic int exp_at(input int w);
        return maxi(w + 1, last_c + last_gap);
    endfunction

    task automatic push(input int at, input logic [1:0] typ);
        exp_t e;
        int   g;
        e.at = at;
        e.typ = typ;
        exp_q.push_back(e);
        g = (typ == 2'b01) ? int'(t_prech) : int'(t_refr);
        last_c = at;
        last_gap = maxi(g, 1);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected strobe", int'(cmd_type), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(cyc == e.at, "R6 strobe cycle", cyc, e.at);
                chk(cmd_type == e.typ, "R2 strobe type", int'(cmd_type), int'(e.typ));
            end
        end
    end

    task automatic nxt();
        @(posedge clk);
        #1;
    endtask

    task automatic look();
        @(negedge clk);
    endtask

    // drive a write for the current cycle; returns at the start of the next
    task automatic wr(input logic [2:0] code);
        wr_en = 1'b1;
        wr_data = code;
        nxt();
        wr_en = 1'b0;
        wr_data = 3'b000;
    endtask

    task automatic pulse(input bit ent);
        if (ent) sr_enter = 1'b1;
        else     sr_exit = 1'b1;
        nxt();
        sr_enter = 1'b0;
        sr_exit = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) nxt();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        int k;
        int w;
        int x;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        look();
        chk(cke == 1'b0, "R1 cke", cke, 0);
        chk(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(err == 1'b0, "R1 err", err, 0);
        chk(rd_data == 3'b000, "R4 rd_data", int'(rd_data), 0);
        nxt();

        // commands before clock enable
        wr(3'b010); look();
        chk(err == 1'b1, "R10 precharge before cke err", err, 1);
        chk(cke == 1'b0, "R10 cke stays low", cke, 0);
        nxt();
        wr(3'b100); look();
        chk(err == 1'b1, "R10 refresh before cke err", err, 1);
        nxt();

        // prohibited and no-op codes
        wr(3'b001); look();
        chk(err == 1'b1, "R3 code 001", err, 1);
        nxt();
        wr(3'b110); look();
        chk(err == 1'b1, "R3 code 110", err, 1);
        nxt();
        wr(3'b000); look();
        chk(err == 1'b0, "R2 code 000 no error", err, 0);
        nxt();

        // self-refresh request before cke is ignored
        pulse(1'b1); look();
        chk(cke == 1'b0, "R11 sr_enter before cke ignored", cke, 0);
        nxt();

        // raise clock enable
        wr(3'b011); look();
        chk(cke == 1'b1, "R5 cke raised", cke, 1);
        chk(err == 1'b0, "R5 no error", err, 0);
        chk(rd_data == 3'b000, "R4 rd_data after write", int'(rd_data), 0);
        nxt();

        // locked while automatic refresh enabled
        auto_ref_en = 1'b1;
        wr(3'b010); look();
        chk(err == 1'b0, "R9 locked write no err", err, 0);
        nxt();
        wr(3'b101); look();
        chk(err == 1'b0, "R9 locked bad code no err", err, 0);
        chk(cke == 1'b1, "R9 cke unchanged", cke, 1);
        nxt();
        auto_ref_en = 1'b0;
        idle(2);

        // precharge, refresh held during interval, third write dropped
        k = cyc;
        push(exp_at(k), 2'b01);
        wr(3'b010);
        w = cyc;
        push(exp_at(w), 2'b10);
        wr(3'b100);
        look();
        chk(busy == 1'b1, "R7 busy while held", busy, 1);
        chk(rd_data == 3'b000, "R4 rd_data", int'(rd_data), 0);
        nxt();
        wr(3'b010); look();
        chk(err == 1'b1, "R8 write while held dropped", err, 1);
        chk(busy == 1'b0, "R7 busy clear at strobe", busy, 0);
        chk(cmd_valid == 1'b1, "R7 held command strobes", cmd_valid, 1);
        nxt();
        idle(8);

        // two refreshes need two writes
        k = cyc;
        push(exp_at(k), 2'b10);
        wr(3'b100);
        w = cyc;
        push(exp_at(w), 2'b10);
        wr(3'b100);
        idle(10);

        // zero spacing is clamped to one cycle
        t_prech = '0;
        k = cyc;
        push(exp_at(k), 2'b01);
        wr(3'b010);
        w = cyc;
        push(exp_at(w), 2'b01);
        wr(3'b010);
        idle(4);
        t_prech = TW'(3);
        idle(2);

        // self-refresh request during interval ignored
        k = cyc;
        push(exp_at(k), 2'b10);
        wr(3'b100);
        pulse(1'b1); look();
        chk(cke == 1'b1, "R11 sr_enter during interval ignored", cke, 1);
        nxt();
        idle(8);

        // self-refresh with a held command
        pulse(1'b1);
        wr(3'b100);
        look();
        chk(cke == 1'b0, "R11 cke low in self-refresh", cke, 0);
        chk(busy == 1'b1, "R11 command held in self-refresh", busy, 1);
        nxt();
        idle(5);
        look();
        chk(cmd_valid == 1'b0, "R13 no strobe in self-refresh", cmd_valid, 0);
        nxt();
        x = cyc;
        push(maxi(x + 2, last_c + last_gap), 2'b10);
        pulse(1'b0); look();
        chk(cke == 1'b1, "R12 cke back high", cke, 1);
        nxt();
        idle(8);

        // sticky clock enable and repeated 011
        wr(3'b011); look();
        chk(cke == 1'b1, "R5 cke stays high", cke, 1);
        chk(err == 1'b0, "R5 repeat 011 no error", err, 0);
        nxt();
        wr(3'b111); look();
        chk(cke == 1'b1, "R5 no code lowers cke", cke, 1);
        chk(err == 1'b1, "R3 code 111", err, 1);
        nxt();
        idle(4);
        chk(exp_q.size() == 0, "R2 all expected strobes seen", exp_q.size(), 0);
        finish_run();
    end
endmodule